// File: doc/BRIEF.md
# Load/Store Data Lane Aligner

This block sits between a 32-bit processor core and its memory data bus. It handles byte, half-word and word transfers in both directions.

On a load it takes the raw 32-bit read bus. Using the two low address bits and the selected byte order, it finds the addressed byte or half-word. It then returns that value zero-extended or sign-extended to 32 bits. On a store it copies the source value across every lane of the write bus that could be written. It also produces one write enable per byte lane.

Each request is a one-cycle strobe. The result appears in registers on the following clock edge. Two conditions are reported as errors, and for a store either one blocks all byte writes:

- a half-word access at an odd address;
- a signed access combined with a store direction.

Top module: `lsu_lane_align`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero on that edge.
- R2: `done` is 1 on the cycle after a cycle with `req_vld` high. After a cycle with `req_vld` low, every output is zero.
- R3: Access decode: `acc_word`=1 selects a word transfer and `acc_sgn`/`acc_half` are then ignored. Otherwise {`acc_sgn`,`acc_half`} = 00 is an unsigned byte, 01 an unsigned half-word, 10 a signed byte and 11 a signed half-word.
- R4: Byte lane selection. With `big_end`=0, offset n (`addr_lo`) reads bus bits 8n+7:8n. With `big_end`=1, offset n reads bus bits 8(3-n)+7:8(3-n).
- R5: Half-word lane selection. With `big_end`=0, `addr_lo[1]`=0 reads bits 15:0 and `addr_lo[1]`=1 reads bits 31:16. With `big_end`=1 the mapping is reversed.
- R6: A signed byte load copies bit 7 of the byte into bits 31:8. An unsigned byte load fills bits 31:8 with zeros.
- R7: A signed half-word load copies bit 15 of the half-word into bits 31:16. An unsigned half-word load fills bits 31:16 with zeros.
- R8: A word load returns `rd_bus` unchanged. A word store drives `st_data` unchanged with `byte_en`=4'b1111.
- R9: A half-word store drives `st_data[15:0]` onto both bits 15:0 and bits 31:16. A byte store drives `st_data[7:0]` onto all four lanes.
- R10: `byte_en` bit i enables bus bits 8i+7:8i. A byte store sets only the lane chosen by R4. A half-word store sets 4'b0011 or 4'b1100, following the half chosen by R5.
- R11: A non-word store with `acc_sgn`=1 sets `err_illegal` and forces `byte_en` to zero.
- R12: A half-word access with `addr_lo[0]`=1 sets `err_misalign`. For a store, it also forces `byte_en` to zero.
- R13: A load leaves `wr_bus` and `byte_en` at zero. A store leaves `ld_data` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | One-cycle request strobe |
| acc_load | input | 1 | 1 = load, 0 = store |
| acc_sgn | input | 1 | Signed access select |
| acc_half | input | 1 | Half-word (1) or byte (0) select |
| acc_word | input | 1 | Word transfer; overrides sign and half selects |
| big_end | input | 1 | 1 = big-endian lane mapping |
| addr_lo | input | 2 | Low two address bits |
| rd_bus | input | 32 | Raw read data from memory |
| st_data | input | 32 | Source data for stores |
| done | output | 1 | Result valid, one cycle after the request |
| ld_data | output | 32 | Aligned and extended load result |
| wr_bus | output | 32 | Replicated store data for the bus |
| byte_en | output | 4 | Byte-lane write enables |
| err_illegal | output | 1 | Signed store requested |
| err_misalign | output | 1 | Half-word access at an odd address |

## Verification
The assertions assume that every control input is at a known value whenever `req_vld` is high. They also assume that requests are single-cycle strobes, so every result can be related to the inputs one edge earlier.

The bench drives all inputs only at falling edges and holds them steady across the capturing rising edge. It drops `req_vld` after each request. It sweeps every offset, both byte orders and both sign modes, and applies odd addresses and signed stores on purpose, so the error paths are exercised without breaking the input assumptions.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 2 * BYTE_W;
    localparam int NLANE  = DATA_W / BYTE_W;
    localparam int LIDX_W = $clog2(NLANE);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic              done;
        logic [DATA_W-1:0] ld_data;
        logic [DATA_W-1:0] wr_bus;
        logic [NLANE-1:0]  byte_en;
        logic              err_illegal;
        logic              err_misalign;
    } align_out_t;
endpackage

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
    import lsu_align_pkg::*;
(
    input  logic [DATA_W-1:0] rd_bus,
    input  logic [LIDX_W-1:0] addr_lo,
    input  logic              big_end,
    input  logic              sgn,
    input  acc_size_e         size,
    output logic [DATA_W-1:0] ld_val
);
    logic [BYTE_W-1:0] lane [NLANE];
    logic [LIDX_W-1:0] lane_idx;
    logic              hi_half;
    logic [BYTE_W-1:0] sel_b;
    logic [HALF_W-1:0] sel_h;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane[g] = rd_bus[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        lane_idx = big_end ? (LIDX_W'(NLANE-1) - addr_lo) : addr_lo;
        hi_half  = addr_lo[LIDX_W-1] ^ big_end;
        sel_b    = lane[lane_idx];
        sel_h    = hi_half ? rd_bus[DATA_W-1 -: HALF_W] : rd_bus[HALF_W-1:0];
        case (size)
            SZ_BYTE: ld_val = {{(DATA_W-BYTE_W){sgn & sel_b[BYTE_W-1]}}, sel_b};
            SZ_HALF: ld_val = {{(DATA_W-HALF_W){sgn & sel_h[HALF_W-1]}}, sel_h};
            default: ld_val = rd_bus;
        endcase
    end
endmodule

// File: rtl/lsu_store_spread.sv
module lsu_store_spread
    import lsu_align_pkg::*;
(
    input  logic [DATA_W-1:0] st_data,
    input  logic [LIDX_W-1:0] addr_lo,
    input  logic              big_end,
    input  acc_size_e         size,
    output logic [DATA_W-1:0] wr_val,
    output logic [NLANE-1:0]  lane_mask
);
    logic [LIDX_W-1:0] lane_idx;
    logic              hi_half;
    logic [NLANE-1:0]  byte_hit;

    assign lane_idx = big_end ? (LIDX_W'(NLANE-1) - addr_lo) : addr_lo;
    assign hi_half  = addr_lo[LIDX_W-1] ^ big_end;

    for (genvar g = 0; g < NLANE; g++) begin : g_hit
        assign byte_hit[g] = (lane_idx == LIDX_W'(g));
    end

    always_comb begin
        case (size)
            SZ_BYTE: begin
                wr_val    = {NLANE{st_data[BYTE_W-1:0]}};
                lane_mask = byte_hit;
            end
            SZ_HALF: begin
                wr_val    = {(DATA_W/HALF_W){st_data[HALF_W-1:0]}};
                lane_mask = hi_half ? {{(NLANE/2){1'b1}}, {(NLANE/2){1'b0}}}
                                    : {{(NLANE/2){1'b0}}, {(NLANE/2){1'b1}}};
            end
            default: begin
                wr_val    = st_data;
                lane_mask = '1;
            end
        endcase
    end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic              acc_load,
    input  logic              acc_sgn,
    input  logic              acc_half,
    input  logic              acc_word,
    input  logic              big_end,
    input  logic [1:0]        addr_lo,
    input  logic [31:0]       rd_bus,
    input  logic [31:0]       st_data,
    output logic              done,
    output logic [31:0]       ld_data,
    output logic [31:0]       wr_bus,
    output logic [3:0]        byte_en,
    output logic              err_illegal,
    output logic              err_misalign
);
    acc_size_e         size;
    logic [DATA_W-1:0] ld_val;
    logic [DATA_W-1:0] sp_bus;
    logic [NLANE-1:0]  sp_mask;
    logic              bad_sign;
    logic              bad_align;
    align_out_t        out_d;
    align_out_t        out_q;

    assign size = acc_word ? SZ_WORD : (acc_half ? SZ_HALF : SZ_BYTE);

    lsu_load_ext u_load (
        .rd_bus  (rd_bus),
        .addr_lo (addr_lo),
        .big_end (big_end),
        .sgn     (acc_sgn),
        .size    (size),
        .ld_val  (ld_val)
    );

    lsu_store_spread u_store (
        .st_data   (st_data),
        .addr_lo   (addr_lo),
        .big_end   (big_end),
        .size      (size),
        .wr_val    (sp_bus),
        .lane_mask (sp_mask)
    );

    always_comb begin
        bad_sign  = acc_sgn & ~acc_load & ~acc_word;
        bad_align = (size == SZ_HALF) & addr_lo[0];
        out_d     = '0;
        if (req_vld) begin
            out_d.done         = 1'b1;
            out_d.err_illegal  = bad_sign;
            out_d.err_misalign = bad_align;
            if (acc_load) begin
                out_d.ld_data = ld_val;
            end else begin
                out_d.wr_bus  = sp_bus;
                out_d.byte_en = (bad_sign | bad_align) ? '0 : sp_mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign done         = out_q.done;
    assign ld_data      = out_q.ld_data;
    assign wr_bus       = out_q.wr_bus;
    assign byte_en      = out_q.byte_en;
    assign err_illegal  = out_q.err_illegal;
    assign err_misalign = out_q.err_misalign;
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_vld,
    input logic        acc_load,
    input logic        acc_sgn,
    input logic        acc_half,
    input logic        acc_word,
    input logic [1:0]  addr_lo,
    input logic        done,
    input logic [31:0] ld_data,
    input logic [31:0] wr_bus,
    input logic [3:0]  byte_en,
    input logic        err_illegal,
    input logic        err_misalign
);
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) req_vld |=> done); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !req_vld |=> (!done && byte_en == 4'd0 && !err_illegal && !err_misalign)); // R2
    AST_SBYTE_EXT: assert property (@(posedge clk) disable iff (rst) (req_vld && acc_load && acc_sgn && !acc_half && !acc_word) |=> (ld_data[31:8] == {24{ld_data[7]}})); // R6
    AST_UHALF_EXT: assert property (@(posedge clk) disable iff (rst) (req_vld && acc_load && !acc_sgn && acc_half && !acc_word) |=> (ld_data[31:16] == 16'd0)); // R7
    AST_HALF_MIRROR: assert property (@(posedge clk) disable iff (rst) (req_vld && !acc_load && acc_half && !acc_word) |=> (wr_bus[31:16] == wr_bus[15:0])); // R9
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst) (req_vld && !acc_load && !acc_half && !acc_word) |=> $onehot0(byte_en)); // R10
    AST_SIGNED_STORE: assert property (@(posedge clk) disable iff (rst) (req_vld && !acc_load && acc_sgn && !acc_word) |=> (err_illegal && byte_en == 4'd0)); // R11
    AST_ODD_HALF: assert property (@(posedge clk) disable iff (rst) (req_vld && acc_half && !acc_word && addr_lo[0]) |=> err_misalign); // R12
    AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (req_vld && acc_load) |=> (byte_en == 4'd0)); // R13
endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_vld      (req_vld),
    .acc_load     (acc_load),
    .acc_sgn      (acc_sgn),
    .acc_half     (acc_half),
    .acc_word     (acc_word),
    .addr_lo      (addr_lo),
    .done         (done),
    .ld_data      (ld_data),
    .wr_bus       (wr_bus),
    .byte_en      (byte_en),
    .err_illegal  (err_illegal),
    .err_misalign (err_misalign)
);

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic        acc_load = 1'b0, acc_sgn = 1'b0, acc_half = 1'b0, acc_word = 1'b0, big_end = 1'b0;
    logic [1:0]  addr_lo = 2'd0;
    logic [31:0] rd_bus = 32'd0, st_data = 32'd0;
    logic        done, err_illegal, err_misalign;
    logic [31:0] ld_data, wr_bus;
    logic [3:0]  byte_en;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    lsu_lane_align u_dut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .acc_load(acc_load), .acc_sgn(acc_sgn),
        .acc_half(acc_half), .acc_word(acc_word), .big_end(big_end), .addr_lo(addr_lo),
        .rd_bus(rd_bus), .st_data(st_data), .done(done), .ld_data(ld_data), .wr_bus(wr_bus),
        .byte_en(byte_en), .err_illegal(err_illegal), .err_misalign(err_misalign)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected byte lane number from R4.
    function automatic int exp_lane(input logic be, input logic [1:0] a);
        return be ? 3 - int'(a) : int'(a);
    endfunction

    // Expected load result from R3..R8.
    function automatic logic [31:0] exp_load(input logic [31:0] rd, input logic be, input logic [1:0] a,
                                             input logic s, input logic h, input logic w);
        logic [7:0]  b;
        logic [15:0] hw;
        if (w) return rd;
        if (h) begin
            hw = (a[1] != be) ? rd[31:16] : rd[15:0];
            return s ? {{16{hw[15]}}, hw} : {16'd0, hw};
        end
        b = rd[8*exp_lane(be, a) +: 8];
        return s ? {{24{b[7]}}, b} : {24'd0, b};
    endfunction

    task automatic do_req(input logic l, input logic s, input logic h, input logic w,
                          input logic be, input logic [1:0] a, input logic [31:0] rd, input logic [31:0] st);
        @(negedge clk);
        req_vld = 1'b1; acc_load = l; acc_sgn = s; acc_half = h; acc_word = w;
        big_end = be; addr_lo = a; rd_bus = rd; st_data = st;
        @(negedge clk);
        req_vld = 1'b0;
        chk("R2 done", {31'd0, done}, 32'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 ld_data", ld_data, 32'd0);
        chk("R1 byte_en", {28'd0, byte_en}, 32'd0);
        chk("R1 flags", {30'd0, err_illegal, err_misalign}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_byte_loads();
        logic [31:0] rd = 32'h8A7B_C96D;
        for (int be = 0; be < 2; be++)
            for (int a = 0; a < 4; a++)
                for (int s = 0; s < 2; s++) begin
                    do_req(1'b1, s[0], 1'b0, 1'b0, be[0], a[1:0], rd, 32'hFFFF_FFFF);
                    chk("R4 R6 byte load", ld_data, exp_load(rd, be[0], a[1:0], s[0], 1'b0, 1'b0));
                    chk("R13 load no write", {wr_bus[31:4], byte_en}, 32'd0);
                end
    endtask

    task automatic t_half_loads();
        logic [31:0] rd = 32'h9234_5678;
        for (int be = 0; be < 2; be++)
            for (int a = 0; a < 4; a += 2)
                for (int s = 0; s < 2; s++) begin
                    do_req(1'b1, s[0], 1'b1, 1'b0, be[0], a[1:0], rd, 32'd0);
                    chk("R5 R7 half load", ld_data, exp_load(rd, be[0], a[1:0], s[0], 1'b1, 1'b0));
                    chk("R12 no misalign", {31'd0, err_misalign}, 32'd0);
                end
    endtask

    task automatic t_word();
        do_req(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 32'hF00D_1234, 32'd0);
        chk("R8 R3 word load", ld_data, 32'hF00D_1234);
        do_req(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 32'd0, 32'hCAFE_BEEF);
        chk("R8 word store bus", wr_bus, 32'hCAFE_BEEF);
        chk("R8 word store en", {28'd0, byte_en}, 32'hF);
        chk("R3 word ignores sign", {31'd0, err_illegal}, 32'd0);
        chk("R13 store ld zero", ld_data, 32'd0);
    endtask

    task automatic t_stores();
        logic [31:0] st = 32'h1122_A3B4;
        for (int be = 0; be < 2; be++)
            for (int a = 0; a < 4; a++) begin
                do_req(1'b0, 1'b0, 1'b0, 1'b0, be[0], a[1:0], 32'd0, st);
                chk("R9 byte store bus", wr_bus, 32'hB4B4_B4B4);
                chk("R10 byte store en", {28'd0, byte_en}, 32'(1 << exp_lane(be[0], a[1:0])));
            end
        for (int be = 0; be < 2; be++)
            for (int a = 0; a < 4; a += 2) begin
                do_req(1'b0, 1'b0, 1'b1, 1'b0, be[0], a[1:0], 32'd0, st);
                chk("R9 half store bus", wr_bus, 32'hA3B4_A3B4);
                chk("R10 half store en", {28'd0, byte_en}, (a[1] != be[0]) ? 32'hC : 32'h3);
            end
    endtask

    task automatic t_errors();
        do_req(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 32'd0, 32'h55);
        chk("R11 signed store flag", {31'd0, err_illegal}, 32'd1);
        chk("R11 signed store en", {28'd0, byte_en}, 32'd0);
        do_req(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 32'd0, 32'h55);
        chk("R11 signed half store", {27'd0, byte_en, err_illegal}, 32'd1);
        do_req(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 32'h1234);
        chk("R12 odd half store flag", {31'd0, err_misalign}, 32'd1);
        chk("R12 odd half store en", {28'd0, byte_en}, 32'd0);
        do_req(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 32'h1234_5678, 32'd0);
        chk("R12 odd half load flag", {31'd0, err_misalign}, 32'd1);
        do_req(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 32'h1234_5678, 32'd0);
        chk("R12 odd byte legal", {30'd0, err_illegal, err_misalign}, 32'd0);
    endtask

    task automatic t_idle();
        do_req(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 32'd0, 32'hDEAD_0001);
        @(negedge clk);
        chk("R2 idle done", {31'd0, done}, 32'd0);
        chk("R2 idle byte_en", {28'd0, byte_en}, 32'd0);
        chk("R2 idle wr_bus", wr_bus, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_byte_loads();
        t_half_loads();
        t_word();
        t_stores();
        t_errors();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule